// File: doc/BRIEF.md
# DRAM Bank Match and Page-Hit Unit

This unit sits between the system bus and a DRAM sequencer. For every transfer it decides whether one of the configured DRAM banks claims the address. It also decides whether the access may reuse the row that bank already has open, and which access style the sequencer should use. The unit produces only the decision. Strobe waveforms, refresh timing and data movement are handled by other blocks.

Each bank has its own base address, don't-care mask and control word. The control word holds a page size code, a page mode code, a read enable and a write enable. The unit keeps one open-page record per bank. A pulse on the refresh-done input closes every open page. Writing to any configuration register of a bank closes that bank's open page.

Top module: `dram_page_sel`

## Requirements
- R1: A bank claims an address when the address equals the bank base on every bit whose mask bit is 0. Address bits whose mask bit is 1 are not compared.
- R2: When several banks claim an address, the lowest-numbered bank is selected.
- R3: A read transfer is not serviced when the selected bank has its read enable (control bit 5) at 0. In that case `res_nomatch` is 1, `res_hit` is 0 and `res_mode` is 00. A transfer that no bank claims gives the same result.
- R4: A write transfer (`xfer_write`=1) is not serviced when the selected bank has its write enable (control bit 4) at 0. The result is then a no-match.
- R5: The page size code in control bits [1:0] sets the page size: 00 is 512 bytes, 01 is 1 KB and 10 is 2 KB. The page number is the address shifted right by 9 plus the code.
- R6: The page mode code in control bits [3:2] selects burst page mode with 01 and fast page mode with 11. In those modes, the first serviced access to a page reports a miss and opens that page. A later serviced access with the same page number reports `res_hit`=1.
- R7: Page mode 00 (normal) is page-disabled, and so are the reserved page mode 10 and the reserved page size 11. With any of these, every access reports a miss and `res_mode`=00, and the bank is left with no open page.
- R8: A serviced access to a page-enabled bank reports that bank's page mode code on `res_mode`. Each bank uses its own mode.
- R9: A pulse on `refresh_done` closes the open page of every bank.
- R10: A write to any configuration register of a bank closes that bank's open page. Other banks keep their open pages.
- R11: A transfer that gives a no-match leaves every open-page record unchanged.
- R12: Register address {bank, sel} maps sel 0 to base, sel 1 to mask and sel 2 to control. The read data is registered, so `cfg_rdata` shows the addressed register one cycle after `cfg_addr` is presented. After reset all registers read as 0.
- R13: The results are registered. `res_valid` follows `xfer_valid` by one cycle. While `res_valid` is 0, `res_hit` and `res_nomatch` are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CA_W | Register address: bank index above a 2-bit register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Registered read data of the addressed register |
| xfer_valid | input | 1 | A transfer is presented this cycle |
| xfer_write | input | 1 | 1 for a write transfer, 0 for a read |
| xfer_addr | input | ADDR_W | Transfer byte address |
| refresh_done | input | 1 | Pulse: refresh finished, all rows closed |
| res_valid | output | 1 | Result valid |
| res_bank | output | BK_W | Selected bank (0 on no-match) |
| res_hit | output | 1 | Access falls in the bank's open page |
| res_mode | output | 2 | Access style: 00 normal, 01 burst page, 11 fast page |
| res_nomatch | output | 1 | No bank services the transfer |

## Verification
The hardest condition to reach is an open page that survives an event which must not disturb it. Examples are an unclaimed transfer, a write blocked by its enable, and a configuration write to the other bank. To build it, the stimulus first opens a page with a serviced read, then applies the event, then returns to the same page and expects a hit. The page size and page mode codes are swept through all sixteen combinations. For each combination, the addresses are chosen so that each access stays in or leaves the current page differently depending on whether the page is 512 bytes, 1 KB or 2 KB.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int PAGE_LSB = 9;  // smallest page is 512 bytes

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_BURST  = 2'b01,
    PM_RSVD   = 2'b10,
    PM_FAST   = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    PS_512  = 2'b00,
    PS_1K   = 2'b01,
    PS_2K   = 2'b10,
    PS_RSVD = 2'b11
  } psize_e;

  // control word layout: [5] rd_en, [4] wr_en, [3:2] mode, [1:0] size
  typedef struct packed {
    logic   rd_en;
    logic   wr_en;
    pmode_e mode;
    psize_e psize;
  } bank_ctrl_t;
endpackage

// File: rtl/dps_cfg_regs.sv
module dps_cfg_regs
  import dps_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NBANK  = 2,
  parameter int BK_W   = $clog2(NBANK),
  parameter int CA_W   = BK_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic [ADDR_W-1:0] base_o [NBANK],
  output logic [ADDR_W-1:0] mask_o [NBANK],
  output bank_ctrl_t        ctrl_o [NBANK],
  output logic [NBANK-1:0]  touch_o
);
  localparam int CW = $bits(bank_ctrl_t);

  logic [BK_W-1:0] sel_bank;
  logic [1:0]      sel_reg;

  assign sel_bank = cfg_addr[CA_W-1:2];
  assign sel_reg  = cfg_addr[1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign touch_o[b] = cfg_we && (sel_bank == BK_W'(b)) && (sel_reg != 2'd3);

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[b] <= '0;
        mask_o[b] <= '0;
        ctrl_o[b] <= '0;
      end else if (touch_o[b]) begin
        case (sel_reg)
          2'd0:    base_o[b] <= cfg_wdata;
          2'd1:    mask_o[b] <= cfg_wdata;
          default: ctrl_o[b] <= bank_ctrl_t'(cfg_wdata[CW-1:0]);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (sel_reg)
        2'd0:    cfg_rdata <= base_o[sel_bank];
        2'd1:    cfg_rdata <= mask_o[sel_bank];
        2'd2:    cfg_rdata <= {{(ADDR_W-CW){1'b0}}, ctrl_o[sel_bank]};
        default: cfg_rdata <= '0;
      endcase
    end
  end

  // R12: a control write is visible in the bank's control field next cycle
  p_ctrl_load_r12: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && sel_reg == 2'd2 && sel_bank == '0)
      |=> (ctrl_o[0] == $past(cfg_wdata[CW-1:0])));
endmodule

// File: rtl/dps_bank_cmp.sv
module dps_bank_cmp
  import dps_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PL     = PAGE_LSB,
  parameter int PW     = ADDR_W - PL
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  bank_ctrl_t        ctrl,
  input  logic              open_vld,
  input  logic [PW-1:0]     open_page,
  output logic              addr_match,
  output logic              pageable,
  output logic              page_hit
);
  logic [PW-1:0] ign;

  assign addr_match = (((addr ^ base) & ~mask) == '0);
  assign pageable   = ((ctrl.mode == PM_BURST) || (ctrl.mode == PM_FAST)) &&
                      (ctrl.psize != PS_RSVD);

  // larger pages ignore the low bits of the 512-byte page number
  always_comb begin
    ign = '0;
    case (ctrl.psize)
      PS_1K: ign[0] = 1'b1;
      PS_2K: ign[1:0] = 2'b11;
      default: ign = '0;
    endcase
  end

  assign page_hit = pageable && open_vld &&
                    (((addr[ADDR_W-1:PL] ^ open_page) & ~ign) == '0);
endmodule

// File: rtl/dps_page_track.sv
module dps_page_track #(
  parameter int PW    = 23,
  parameter int NBANK = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [NBANK-1:0] clr_bank,
  input  logic [NBANK-1:0] upd,
  input  logic             upd_open,
  input  logic [PW-1:0]    upd_page,
  output logic [NBANK-1:0] open_q,
  output logic [PW-1:0]    page_q [NBANK]
);
  for (genvar b = 0; b < NBANK; b++) begin : g_trk
    always_ff @(posedge clk) begin
      if (rst || clr_all || clr_bank[b]) begin
        open_q[b] <= 1'b0;
        page_q[b] <= '0;
      end else if (upd[b]) begin
        open_q[b] <= upd_open;
        page_q[b] <= upd_page;
      end
    end

    // R10: a configuration write closes this bank's page
    p_cfg_close_r10: assert property (@(posedge clk) disable iff (rst)
      clr_bank[b] |=> !open_q[b]);

    // R11: without an update or a clear, the record holds
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!upd[b] && !clr_bank[b] && !clr_all) |=> $stable(open_q[b]));
  end

  // R9: refresh closes every page
  p_refresh_close_r9: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (open_q == '0));
endmodule

// File: rtl/dram_page_sel.sv
module dram_page_sel
  import dps_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NBANK  = 2,
  parameter int BK_W   = $clog2(NBANK),
  parameter int CA_W   = BK_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              xfer_valid,
  input  logic              xfer_write,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              refresh_done,
  output logic              res_valid,
  output logic [BK_W-1:0]   res_bank,
  output logic              res_hit,
  output logic [1:0]        res_mode,
  output logic              res_nomatch
);
  localparam int PW = ADDR_W - PAGE_LSB;

  logic [ADDR_W-1:0] base [NBANK];
  logic [ADDR_W-1:0] mask [NBANK];
  bank_ctrl_t        ctrl [NBANK];
  logic [NBANK-1:0]  touch;
  logic [NBANK-1:0]  open_q;
  logic [PW-1:0]     page_q [NBANK];
  logic [NBANK-1:0]  amatch, pgable, phit, upd;

  logic [BK_W-1:0] sel;
  logic            found, en_ok, serve;

  dps_cfg_regs #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BK_W(BK_W), .CA_W(CA_W)) u_regs (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .base_o(base), .mask_o(mask), .ctrl_o(ctrl), .touch_o(touch)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    dps_bank_cmp #(.ADDR_W(ADDR_W), .PL(PAGE_LSB), .PW(PW)) u_cmp (
      .addr(xfer_addr), .base(base[b]), .mask(mask[b]), .ctrl(ctrl[b]),
      .open_vld(open_q[b]), .open_page(page_q[b]),
      .addr_match(amatch[b]), .pageable(pgable[b]), .page_hit(phit[b])
    );
    assign upd[b] = serve && (sel == BK_W'(b));
  end

  // lowest-numbered claiming bank wins
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (amatch[b]) begin
        sel   = BK_W'(b);
        found = 1'b1;
      end
    end
  end

  assign en_ok = xfer_write ? ctrl[sel].wr_en : ctrl[sel].rd_en;
  assign serve = xfer_valid && found && en_ok;

  dps_page_track #(.PW(PW), .NBANK(NBANK)) u_trk (
    .clk, .rst, .clr_all(refresh_done), .clr_bank(touch), .upd,
    .upd_open(pgable[sel]), .upd_page(xfer_addr[ADDR_W-1:PAGE_LSB]),
    .open_q, .page_q
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_bank    <= '0;
      res_hit     <= 1'b0;
      res_mode    <= PM_NORMAL;
      res_nomatch <= 1'b0;
    end else begin
      res_valid   <= xfer_valid;
      res_nomatch <= xfer_valid && !serve;
      res_bank    <= serve ? sel : '0;
      res_hit     <= serve && phit[sel];
      res_mode    <= (serve && pgable[sel]) ? ctrl[sel].mode : PM_NORMAL;
    end
  end

  // R13: result one cycle after request
  p_valid_follow_r13: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |=> res_valid);
  p_quiet_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && !res_nomatch));
  // R6: a hit only occurs in a page-reusing mode
  p_hit_mode_r6: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_mode == PM_BURST || res_mode == PM_FAST));
  // R3: a no-match carries no hit and normal mode
  p_nomatch_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    res_nomatch |-> (!res_hit && res_mode == PM_NORMAL));
  // R7: reserved mode code is never reported
  p_no_rsvd_mode_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_mode != PM_RSVD));
endmodule

// File: tb/dram_page_sel_bench.sv
module dram_page_sel_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          xfer_valid = 1'b0, xfer_write = 1'b0;
  logic [AW-1:0] xfer_addr = '0;
  logic          refresh_done = 1'b0;
  logic          res_valid, res_hit, res_nomatch;
  logic [0:0]    res_bank;
  logic [1:0]    res_mode;

  int tests = 0, fails = 0;
  bit done = 0;

  // independent model state
  logic [AW-1:0] m_base [2];
  logic [AW-1:0] m_mask [2];
  logic [5:0]    m_ctrl [2];
  bit            m_open [2];
  longint        m_page [2];

  dram_page_sel u_dram_page_sel (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .xfer_valid, .xfer_write, .xfer_addr, .refresh_done,
    .res_valid, .res_bank, .res_hit, .res_mode, .res_nomatch
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wcfg(input int bank, input int sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {bank[0], sel[1:0]}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 0) m_base[bank] = d;
    if (sel == 1) m_mask[bank] = d;
    if (sel == 2) m_ctrl[bank] = d[5:0];
    if (sel != 3) m_open[bank] = 0;
  endtask

  task automatic rdchk(input int bank, input int sel, input logic [AW-1:0] exp, input string req);
    @(negedge clk);
    cfg_addr = {bank[0], sel[1:0]};
    @(negedge clk);
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic refresh();
    @(negedge clk);
    refresh_done = 1'b1;
    @(negedge clk);
    refresh_done = 1'b0;
    m_open[0] = 0; m_open[1] = 0;
  endtask

  task automatic access(input logic [AW-1:0] a, input bit wr, input string req);
    int bk;
    bit serve, pgok, hit;
    int ps, pm;
    longint pg;
    logic [4:0] exp, act;
    bk = -1;
    for (int b = 1; b >= 0; b--)
      if (((a ^ m_base[b]) & ~m_mask[b]) == '0) bk = b;
    serve = 0; pgok = 0; hit = 0; pg = 0; ps = 0; pm = 0;
    if (bk >= 0) begin
      serve = wr ? m_ctrl[bk][4] : m_ctrl[bk][5];
      ps = int'(m_ctrl[bk][1:0]);
      pm = int'(m_ctrl[bk][3:2]);
      pgok = (pm == 1 || pm == 3) && ps != 3;
      pg = longint'(a) >> (9 + ps);
      hit = serve && pgok && m_open[bk] && (m_page[bk] == pg);
    end
    exp = serve ? {1'b0, bk[0], hit, (pgok ? pm[1:0] : 2'b00)} : 5'b10000;
    @(negedge clk);
    xfer_valid = 1'b1; xfer_write = wr; xfer_addr = a;
    @(negedge clk);
    xfer_valid = 1'b0;
    act = {res_nomatch, res_bank, res_hit, res_mode};
    chk(res_valid && act == exp, req, {27'd0, act}, {27'd0, exp});
    if (serve) begin
      m_open[bk] = pgok;
      m_page[bk] = pg;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_base[b] = '0; m_mask[b] = '0; m_ctrl[b] = '0; m_open[b] = 0; m_page[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13 reset state: nothing valid
    chk(!res_valid && !res_hit && !res_nomatch, "R13 reset outputs",
        {29'd0, res_valid, res_hit, res_nomatch}, 32'd0);
    rdchk(1, 2, 32'd0, "R12 reset ctrl");
    rdchk(0, 0, 32'd0, "R12 reset base");
    // R3: after reset bank 0 claims address 0 but reads are disabled
    access(32'h0, 0, "R3 reset read disabled");

    wcfg(0, 0, 32'h0010_0000); wcfg(0, 1, 32'h000F_FFFF); wcfg(0, 2, 32'h3C);
    wcfg(1, 0, 32'h0020_0000); wcfg(1, 1, 32'h000F_FFFF); wcfg(1, 2, 32'h30);
    rdchk(0, 2, 32'h3C, "R12 ctrl readback");
    rdchk(1, 1, 32'h000F_FFFF, "R12 mask readback");

    // R1: mask controls which bits compare
    wcfg(1, 1, 32'h0);
    access(32'h0020_0000, 0, "R1 exact match");
    access(32'h0020_0004, 0, "R1 unmasked bit differs");
    wcfg(1, 1, 32'h0000_00FF);
    access(32'h0020_0004, 0, "R1 masked bit ignored");
    access(32'h0020_0104, 0, "R1 bit above mask");
    wcfg(1, 1, 32'h000F_FFFF);

    // R5 R6 R7 R8: sweep every size and mode code
    for (int ps = 0; ps < 4; ps++) begin
      for (int pm = 0; pm < 4; pm++) begin
        wcfg(1, 2, {26'd0, 2'b11, pm[1:0], ps[1:0]});
        access(32'h0020_0100, 0, "R5 R6 R7 R8 sweep a");
        access(32'h0020_0180, 1, "R5 R6 R7 R8 sweep b");
        access(32'h0020_0300, 0, "R5 R6 R7 R8 sweep c");
        access(32'h0020_0500, 0, "R5 R6 R7 R8 sweep d");
        access(32'h0020_0900, 1, "R5 R6 R7 R8 sweep e");
        access(32'h0020_0904, 0, "R5 R6 R7 R8 sweep f");
      end
    end

    // R2: overlapping banks, bank 0 wins
    wcfg(1, 2, 32'h3C);
    wcfg(1, 0, 32'h0010_0000);
    access(32'h0010_0040, 0, "R2 priority bank0");
    wcfg(0, 2, 32'h1C);
    access(32'h0010_0040, 0, "R3 read disabled despite bank1");
    access(32'h0010_0044, 1, "R4 write enabled serviced");
    wcfg(0, 2, 32'h2C);
    access(32'h0010_0044, 1, "R4 write disabled");
    wcfg(1, 0, 32'h0020_0000);
    wcfg(0, 2, 32'h3C);

    // R11: no-match leaves open page intact
    access(32'h0010_0100, 0, "R11 open page");
    access(32'h0030_0000, 0, "R11 unclaimed");
    access(32'h0010_0104, 0, "R11 hit after unclaimed");
    wcfg(0, 2, 32'h2C);
    access(32'h0010_0100, 0, "R11 reopen");
    access(32'h0010_0900, 1, "R11 blocked write");
    access(32'h0010_0108, 0, "R11 hit after blocked write");

    // R9: refresh closes pages
    refresh();
    access(32'h0010_0108, 0, "R9 miss after refresh");
    access(32'h0010_010C, 0, "R9 hit again");

    // R10: configuration write closes only its bank
    wcfg(1, 2, 32'h34);
    access(32'h0020_0000, 0, "R10 bank1 open burst");
    access(32'h0020_0010, 0, "R8 bank1 burst hit");
    access(32'h0010_0110, 0, "R8 bank0 fast hit");
    wcfg(1, 0, 32'h0020_0000);
    access(32'h0010_0114, 0, "R10 bank0 kept");
    access(32'h0020_0020, 0, "R10 bank1 closed");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule